// File: doc/BRIEF.md
# Bitplane Video Pixel Shifter

This block turns planar video memory data into a stream of pixel codes for a palette lookup stage. Memory delivers 16-bit words, each marked by a one-cycle load strobe. Four words form a group and are held in a four-slot input register. When a group is complete and the shift array has emptied, all 64 bits move into four 16-bit shift registers in one step. The registers then shift one pixel out at each shift step.

A two-bit resolution select sets how the four registers are chained and how often they shift. In low resolution they are four independent planes that give a 4-bit pixel code. In medium resolution they form two 32-bit chains that give a 2-bit code. In high resolution they form one 64-bit chain that gives a 1-bit code. The shift rate grows as the chain gets longer, so every mode uses up a 64-bit group in the same 64 master-clock cycles.

All four tap bits are always driven onto the output, including bits the mode does not use. A mask shows which of them carry meaning. A falling edge on the display-enable input puts the word counter back to its first slot, so the next group starts at a known word.

Top module: `bitplane_shifter`

## Requirements
- R1: After a synchronous reset, `pix_valid`, `pix_bits` and `pix_mask` are all zero, and no pixel appears until four words have been loaded.
- R2: Every fourth load completes a group, and the group moves into the shift array as one 64-bit transfer. When fewer than four words have arrived since the last group, no transfer happens and no pixel is produced. The shift array keeps its contents.
- R3: If the next group is complete before the current group runs out, its first pixel appears on the shift step right after the last pixel of the current group, with no missing step. Loads for the next group may take place while the current group is still shifting.
- R4: Resolution code 2'b00 (low) yields 16 pixels per group. Bit i of pixel k is bit 15-k of word i, where word 0 is the first word loaded. Bit 15 of a word is its first pixel. `pix_mask` is 4'b1111.
- R5: A shift step occurs every 4, 2 or 1 clock cycles in low, medium or high resolution. Each pixel raises `pix_valid` for exactly one cycle per step.
- R6: Resolution code 2'b01 (medium) yields 32 pixels per group. Bit 0 shifts out word 0 and then word 2. Bit 1 shifts out word 1 and then word 3. Each word is sent from bit 15 down to bit 0. `pix_mask` is 4'b0011.
- R7: Resolution codes 2'b10 and 2'b11 (high) yield 64 pixels per group. Bit 0 carries words 0, 1, 2 and 3 in that order, each from bit 15 down to bit 0. `pix_mask` is 4'b0001.
- R8: Tap bits outside the mask are not forced to zero. In every mode, the first pixel of a group shows bit 15 of word i on `pix_bits[i]` for all four i.
- R9: A falling edge of `disp_en` returns the word counter to slot 0. Any words of an unfinished group are dropped, and the next four loads form a fresh group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_en | input | 1 | Display enable; its falling edge resets the word counter |
| load | input | 1 | Strobe that qualifies `word_in` |
| word_in | input | WORD_W | Video memory word |
| res_mode | input | 2 | Resolution: 00 low, 01 medium, 10/11 high |
| pix_valid | output | 1 | High for one cycle per produced pixel |
| pix_bits | output | 4 | The four register tap bits of the pixel |
| pix_mask | output | 4 | Which tap bits are meaningful in the active mode |

## Verification
The bench drives two groups back to back in low and medium resolution. This catches a design that adds an idle step at the group boundary, or one that loses the second group because the next loads overwrote the first. It feeds three words, waits well beyond a full drain period and checks that nothing appears, then adds the fourth word. This exposes a transfer on a partial group, or stale data replayed from the shift array. A display-enable fall after two stray words shows whether the counter really restarts: if it does not, the next group comes out rotated and mixed with the stray words. The bench also compares the unmasked tap bits on the first pixel and times the spacing of the steps, so zeroed taps, wrong chaining and a wrong divider all cause failures.

// File: rtl/bitplane_shifter.sv
module bitplane_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_en,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        res_mode,
  output logic              pix_valid,
  output logic [3:0]        pix_bits,
  output logic [3:0]        pix_mask
);

  localparam int GROUP_W = 4 * WORD_W;
  localparam int REM_W   = $clog2(GROUP_W) + 1;
  localparam int MSB     = WORD_W - 1;

  logic [3:0][WORD_W-1:0] ir, sr, src, nxt;
  logic [3:0]             taps, fill;
  logic [1:0]             wcnt, div;
  logic                   full, disp_q;
  logic [REM_W-1:0]       remain;

  wire is_low    = (res_mode == 2'b00);
  wire is_med    = (res_mode == 2'b01);
  wire is_high   = res_mode[1];
  wire step      = is_high | (is_med & div[0]) | (is_low & (&div));
  wire drained   = (remain == '0);
  wire transfer  = step & drained & full;
  wire shifting  = step & ~drained;
  wire disp_fall = disp_q & ~disp_en;

  wire [REM_W-1:0] first_rem = is_low ? REM_W'(WORD_W - 1) :
                               is_med ? REM_W'(2 * WORD_W - 1) :
                                        REM_W'(GROUP_W - 1);
  wire [3:0] mask_now = is_low ? 4'b1111 : (is_med ? 4'b0011 : 4'b0001);

  assign src = transfer ? ir : sr;

  always_comb begin
    fill = '0;
    if (is_med) begin
      fill[0] = src[2][MSB];
      fill[1] = src[3][MSB];
    end else if (is_high) begin
      fill[0] = src[1][MSB];
      fill[1] = src[2][MSB];
      fill[2] = src[3][MSB];
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign taps[i] = src[i][MSB];
    assign nxt[i]  = {src[i][MSB-1:0], fill[i]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir        <= '0;
      sr        <= '0;
      wcnt      <= '0;
      div       <= '0;
      full      <= 1'b0;
      disp_q    <= 1'b0;
      remain    <= '0;
      pix_valid <= 1'b0;
      pix_bits  <= '0;
      pix_mask  <= '0;
    end else begin
      div    <= div + 2'd1;
      disp_q <= disp_en;

      if (disp_fall) begin
        wcnt <= '0;
      end else if (load) begin
        ir[wcnt] <= word_in;
        wcnt     <= wcnt + 2'd1;
      end

      if (transfer) full <= 1'b0;
      if (load && !disp_fall && wcnt == 2'd3) full <= 1'b1;

      if (transfer || shifting) begin
        sr        <= nxt;
        pix_bits  <= taps;
        pix_mask  <= mask_now;
        pix_valid <= 1'b1;
        remain    <= transfer ? first_rem : remain - REM_W'(1);
      end else begin
        pix_valid <= 1'b0;
      end
    end
  end

  p_group_complete_r2: assert property (@(posedge clk) disable iff (rst)
    (load && wcnt == 2'd3 && !disp_fall) |=> full);

  p_transfer_emits_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(full) && !$past(rst)) |-> pix_valid);

  p_low_rate_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && res_mode == 2'b00 && $past(res_mode) == 2'b00) |=> !pix_valid);

  p_med_rate_r5: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && res_mode == 2'b01 && $past(res_mode) == 2'b01) |=> !pix_valid);

  p_disp_restart_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(disp_en) && !disp_en) |=> (wcnt == 2'd0));

  always_comb begin
    if (pix_valid)
      p_mask_legal_r6: assert (pix_mask == 4'b1111 || pix_mask == 4'b0011 || pix_mask == 4'b0001);
  end

endmodule

// File: tb/bitplane_shifter_test.sv
`timescale 1ns/1ps
module bitplane_shifter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        disp_en = 1'b1;
  logic        load = 1'b0;
  logic [15:0] word_in = '0;
  logic [1:0]  res_mode = 2'b00;
  logic        pix_valid;
  logic [3:0]  pix_bits, pix_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bitplane_shifter #(.WORD_W(16)) uut (
    .clk(clk), .rst(rst), .disp_en(disp_en), .load(load), .word_in(word_in),
    .res_mode(res_mode), .pix_valid(pix_valid), .pix_bits(pix_bits), .pix_mask(pix_mask)
  );

  // {mode, word3, word2, word1, word0}
  localparam logic [65:0] VEC [6] = '{
    {2'b00, 16'hF00F, 16'hA5A5, 16'h4002, 16'h8001},
    {2'b00, 16'h0001, 16'hFFFE, 16'h1234, 16'hC3C3},
    {2'b01, 16'h00FF, 16'hFF00, 16'h8421, 16'h7BDE},
    {2'b01, 16'h5555, 16'hAAAA, 16'h0F0F, 16'hF0F0},
    {2'b10, 16'h8000, 16'h0001, 16'hBEEF, 16'hCAFE},
    {2'b11, 16'h1357, 16'h2468, 16'h9ABC, 16'hDEF0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int plen(input logic [1:0] m);
    return (m == 2'b00) ? 16 : (m == 2'b01) ? 32 : 64;
  endfunction

  function automatic logic [3:0] mask_of(input logic [1:0] m);
    return (m == 2'b00) ? 4'hF : (m == 2'b01) ? 4'h3 : 4'h1;
  endfunction

  function automatic logic [3:0] exp_pix(input logic [1:0] m, input logic [63:0] gw, input int j);
    logic [3:0] e = '0;
    if (m == 2'b00) begin
      for (int i = 0; i < 4; i++) e[i] = gw[16*i + 15 - j];
    end else if (m == 2'b01) begin
      if (j < 16) begin
        e[0] = gw[15 - j];
        e[1] = gw[16 + 15 - j];
      end else begin
        e[0] = gw[32 + 31 - j];
        e[1] = gw[48 + 31 - j];
      end
    end else begin
      e[0] = gw[16*(j/16) + 15 - (j%16)];
    end
    return e;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    load = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    load = 1'b1;
    word_in = w;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic load_group(input logic [63:0] gw);
    for (int i = 0; i < 4; i++) load_word(gw[16*i +: 16]);
  endtask

  task automatic collect(input logic [1:0] m, input logic [127:0] wds, input int groups, input string tag);
    int n, per, got, last, cyc, g, j;
    logic [63:0] gw;
    logic [3:0] mk, e;
    n = plen(m);
    per = (m == 2'b00) ? 4 : (m == 2'b01) ? 2 : 1;
    mk = mask_of(m);
    got = 0;
    last = -1;
    cyc = 0;
    while (got < n * groups && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (pix_valid) begin
        g = got / n;
        j = got % n;
        gw = wds[64*g +: 64];
        e = exp_pix(m, gw, j);
        check((pix_bits & mk) == e, tag, int'(pix_bits & mk), int'(e));
        check(pix_mask == mk, {tag, " mask"}, int'(pix_mask), int'(mk));
        if (j == 0)
          check(pix_bits == {gw[63], gw[47], gw[31], gw[15]}, "R8 unmasked taps",
                int'(pix_bits), int'({gw[63], gw[47], gw[31], gw[15]}));
        if (last >= 0)
          check(cyc - last == per, "R5 step spacing (R3 at boundary)", cyc - last, per);
        last = cyc;
        got++;
      end
    end
    check(got == n * groups, {tag, " pixel count"}, got, n * groups);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int quiet;
    do_reset();
    check(pix_valid == 1'b0, "R1 valid after reset", int'(pix_valid), 0);
    check(pix_bits == 4'h0, "R1 bits after reset", int'(pix_bits), 0);
    check(pix_mask == 4'h0, "R1 mask after reset", int'(pix_mask), 0);
    quiet = 0;
    repeat (30) begin
      @(negedge clk);
      if (pix_valid) quiet++;
    end
    check(quiet == 0, "R1 idle without loads", quiet, 0);

    foreach (VEC[v]) begin
      do_reset();
      res_mode = VEC[v][65:64];
      load_group(VEC[v][63:0]);
      collect(VEC[v][65:64], {64'h0, VEC[v][63:0]}, 1,
              (VEC[v][65:64] == 2'b00) ? "R4 low" : (VEC[v][65:64] == 2'b01) ? "R6 medium" : "R7 high");
    end

    // R2: partial group holds, then completes
    do_reset();
    res_mode = 2'b00;
    load_word(16'h9009);
    load_word(16'h6116);
    load_word(16'h3C3C);
    quiet = 0;
    repeat (100) begin
      @(negedge clk);
      if (pix_valid) quiet++;
    end
    check(quiet == 0, "R2 no pixels with three words", quiet, 0);
    load_word(16'hE001);
    collect(2'b00, {64'h0, 16'hE001, 16'h3C3C, 16'h6116, 16'h9009}, 1, "R2 completed group");

    // R2: drained array with a late partial group stays silent
    do_reset();
    res_mode = 2'b10;
    load_group(64'h0F0F_F0F0_1111_8888);
    collect(2'b10, {64'h0, 64'h0F0F_F0F0_1111_8888}, 1, "R7 first group");
    load_word(16'hABCD);
    load_word(16'h1234);
    load_word(16'h5678);
    quiet = 0;
    repeat (80) begin
      @(negedge clk);
      if (pix_valid) quiet++;
    end
    check(quiet == 0, "R2 drained array stays idle", quiet, 0);
    load_word(16'h9ABC);
    collect(2'b10, {64'h0, 16'h9ABC, 16'h5678, 16'h1234, 16'hABCD}, 1, "R2 late group");

    // R3: back-to-back groups, low and medium
    for (int m = 0; m < 2; m++) begin
      do_reset();
      res_mode = 2'(m);
      load_group(64'h8001_4002_2004_1008);
      fork
        collect(2'(m), {64'hFFFF_0000_AAAA_5555, 64'h8001_4002_2004_1008}, 2, "R3 back-to-back");
        begin
          repeat (10) @(negedge clk);
          load_group(64'hFFFF_0000_AAAA_5555);
        end
      join
    end

    // R9: display-enable fall drops stray words
    do_reset();
    res_mode = 2'b00;
    disp_en = 1'b1;
    load_word(16'hDEAD);
    load_word(16'hBEEF);
    @(negedge clk);
    disp_en = 1'b0;
    @(negedge clk);
    load_group(64'h1248_8421_F00F_0FF0);
    collect(2'b00, {64'h0, 64'h1248_8421_F00F_0FF0}, 1, "R9 counter restart");
    disp_en = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule